// File: doc/BRIEF.md
# Dual-Format Serial PCM Receiver

This block turns a two-channel serial audio stream into parallel samples. Its inputs are a bit clock, a word clock that marks the channel, and one serial data line. The bit clock also clocks all of the block's logic. Each channel word is `SAMPLE_W` bits long and arrives most significant bit first. A static format input picks the framing. One setting is right-aligned framing, where the word ends on the word-clock transition. The other is I2S framing, where the word starts one bit clock after the transition.

After the right-channel word of a frame is complete, the block presents the frame's left and right samples together on registered outputs. It marks them with a one-cycle strobe. A mute input forces both sample outputs to zero. The strobe keeps running while mute is on. The block also accepts the packed frame of exactly `2*SAMPLE_W` bit clocks, in which the word fills each half with no padding.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is held and at reset release, both sample outputs are zero and the strobe is low.
- R2: With format low (right-aligned), word clock high marks the left half and low marks the right half. The last `SAMPLE_W` bits sampled before each word-clock transition, MSB first, form that half's word. Leading padding bits are discarded.
- R3: With format high (I2S), word clock low marks the left half and high marks the right half. The word is the `SAMPLE_W` bits that begin on the second rising bit-clock edge after the transition. Any bits after them in the same half are ignored.
- R4: Packed frames of exactly `2*SAMPLE_W` bit clocks are received correctly in both formats. In I2S the LSB then falls in the first slot of the following half.
- R5: The strobe rises for exactly one cycle per complete frame, after its right word ends. Left and right outputs are updated in that same cycle.
- R6: Between strobes, with mute low, both sample outputs hold their values.
- R7: Mute high forces both sample outputs to zero from the next bit-clock edge. Frames received while muted give zero samples and still raise the strobe. After mute is released, the outputs stay zero until the next strobe.
- R8: The first word-clock transition after reset only sets alignment. The first strobe follows the first complete left-then-right pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk | input | 1 | Word clock, selects the channel half |
| sdata | input | 1 | Serial data, MSB first |
| fmt_i2s | input | 1 | 0 = right-aligned framing, 1 = I2S framing |
| mute | input | 1 | 1 forces both sample outputs to zero |
| left_pcm | output | SAMPLE_W | Left-channel sample |
| right_pcm | output | SAMPLE_W | Right-channel sample |
| frame_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the block with `SAMPLE_W` = 16. At that width a packed frame is 32 bit clocks, so the case where the I2S LSB spills into the next half's first slot is driven directly. Padded halves of 20, 24 and 32 bit clocks exercise discarding of leading bits in right-aligned framing and of trailing bits in I2S. The same width keeps the all-ones, all-zeros and MSB-only words cheap to include.

// File: rtl/pcmrx_pkg.sv
// Shared types for the serial PCM receiver.
// Assumes: nothing beyond standard SystemVerilog.
package pcmrx_pkg;

    // Framing selected by the format input
    typedef enum logic {
        FMT_RIGHT = 1'b0,
        FMT_I2S   = 1'b1
    } fmt_t;

    // Word-capture event handed from the shifter to the pair stage
    typedef struct packed {
        logic fire;
        logic is_left;
    } cap_ev_t;

endpackage

// File: rtl/pcmrx_wclk_track.sv
// Tracks the word clock: finds transitions and records whether alignment
// has been set by a first transition since reset.
// Assumes: wclk is sampled directly on the rising bit-clock edge.
module pcmrx_wclk_track (
    input  logic bclk,
    input  logic rst_n,
    input  logic wclk,
    output logic wclk_q,
    output logic wclk_edge,
    output logic aligned
);

    logic started;

    // A transition counts only once a reference value has been taken
    always_comb wclk_edge = started && (wclk != wclk_q);

    // Keep the previous word-clock value and the alignment flags
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            started <= 1'b0;
            wclk_q  <= 1'b0;
            aligned <= 1'b0;
        end else begin
            started <= 1'b1;
            wclk_q  <= wclk;
            if (wclk_edge)
                aligned <= 1'b1;
        end
    end

endmodule

// File: rtl/pcmrx_shifter.sv
// Shifts serial data in and decides when a complete word is present.
// Right-aligned: the word is the shift register contents at a transition.
// I2S: the word is complete on slot W after a transition (slot 0 is the
// delay bit). In packed frames that slot coincides with the next transition.
// Assumes: the format input is static while a stream runs.
module pcmrx_shifter
    import pcmrx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         sdata,
    input  fmt_t         fmt,
    input  logic         wclk_q,
    input  logic         wclk_edge,
    input  logic         aligned,
    output cap_ev_t      ev,
    output logic [W-1:0] word
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] SLOT_SAT  = CW'(W);
    localparam logic [CW-1:0] SLOT_LAST = CW'(W - 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] slot;

    // Shift every bit in; count slots since the last transition, saturating
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            shreg <= '0;
            slot  <= SLOT_SAT;
        end else begin
            shreg <= {shreg[W-2:0], sdata};
            if (wclk_edge)
                slot <= '0;
            else if (slot != SLOT_SAT)
                slot <= slot + 1'b1;
        end
    end

    // Pick the capture rule and the channel for the selected framing
    generate
        if (W > 1) begin : g_capture
            always_comb begin
                if (fmt == FMT_I2S) begin
                    ev.fire    = (slot == SLOT_LAST);
                    ev.is_left = !wclk_q;
                    word       = {shreg[W-2:0], sdata};
                end else begin
                    ev.fire    = wclk_edge && aligned;
                    ev.is_left = wclk_q;
                    word       = shreg;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pcmrx_pair_out.sv
// Holds the left word until its right partner arrives, then presents both
// on registered outputs with a one-cycle strobe. Mute zeroes the outputs.
// Assumes: the left word of a frame always precedes its right word.
module pcmrx_pair_out
    import pcmrx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  cap_ev_t      ev,
    input  logic [W-1:0] word,
    input  logic         mute,
    output logic [W-1:0] left_pcm,
    output logic [W-1:0] right_pcm,
    output logic         frame_valid
);

    logic [W-1:0] left_hold;

    // Park the left word until the frame completes
    always_ff @(posedge bclk) begin
        if (!rst_n)
            left_hold <= '0;
        else if (ev.fire && ev.is_left)
            left_hold <= word;
    end

    // Present a finished pair, or clear the outputs while muted
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            left_pcm    <= '0;
            right_pcm   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= ev.fire && !ev.is_left;
            if (ev.fire && !ev.is_left) begin
                left_pcm  <= mute ? '0 : left_hold;
                right_pcm <= mute ? '0 : word;
            end else if (mute) begin
                left_pcm  <= '0;
                right_pcm <= '0;
            end
        end
    end

endmodule

// File: rtl/pcm_serial_rx.sv
// Top level of the dual-format serial PCM receiver, clocked by the bit clock.
// Assumes: fmt_i2s is static during a stream; each half carries at least
// SAMPLE_W bit clocks.
module pcm_serial_rx
    import pcmrx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                wclk,
    input  logic                sdata,
    input  logic                fmt_i2s,
    input  logic                mute,
    output logic [SAMPLE_W-1:0] left_pcm,
    output logic [SAMPLE_W-1:0] right_pcm,
    output logic                frame_valid
);

    logic                wclk_q;
    logic                wclk_edge;
    logic                aligned;
    cap_ev_t             ev;
    logic [SAMPLE_W-1:0] word;
    fmt_t                fmt;

    // Map the format pin onto the framing type
    always_comb fmt = fmt_t'(fmt_i2s);

    pcmrx_wclk_track u_track (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .wclk      (wclk),
        .wclk_q    (wclk_q),
        .wclk_edge (wclk_edge),
        .aligned   (aligned)
    );

    pcmrx_shifter #(.W(SAMPLE_W)) u_shift (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .fmt       (fmt),
        .wclk_q    (wclk_q),
        .wclk_edge (wclk_edge),
        .aligned   (aligned),
        .ev        (ev),
        .word      (word)
    );

    pcmrx_pair_out #(.W(SAMPLE_W)) u_pair (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .ev          (ev),
        .word        (word),
        .mute        (mute),
        .left_pcm    (left_pcm),
        .right_pcm   (right_pcm),
        .frame_valid (frame_valid)
    );

endmodule

// File: rtl/pcmrx_checker.sv
// Temporal checks on the receiver's ports, attached by bind.
module pcmrx_checker #(
    parameter int W = 16
) (
    input logic         bclk,
    input logic         rst_n,
    input logic         mute,
    input logic [W-1:0] left_pcm,
    input logic [W-1:0] right_pcm,
    input logic         frame_valid
);

    // R1: outputs are clear when reset is released
    a_r1_reset_clear: assert property (@(posedge bclk)
        $rose(rst_n) |-> (left_pcm == '0 && right_pcm == '0 && !frame_valid))
        else $error("R1 outputs not clear after reset");

    // R5: the strobe never lasts two cycles
    a_r5_single_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid |=> !frame_valid)
        else $error("R5 strobe longer than one cycle");

    // R6: left output changes only with a strobe or a mute
    a_r6_left_hold: assert property (@(posedge bclk) disable iff (!rst_n)
        !$stable(left_pcm) |-> (frame_valid || $past(mute)))
        else $error("R6 left output changed without strobe");

    // R6: right output changes only with a strobe or a mute
    a_r6_right_hold: assert property (@(posedge bclk) disable iff (!rst_n)
        !$stable(right_pcm) |-> (frame_valid || $past(mute)))
        else $error("R6 right output changed without strobe");

    // R7: mute clears both outputs on the next edge
    a_r7_mute_zero: assert property (@(posedge bclk) disable iff (!rst_n)
        mute |=> (left_pcm == '0 && right_pcm == '0))
        else $error("R7 outputs not zero under mute");

endmodule

bind pcm_serial_rx pcmrx_checker #(.W(SAMPLE_W)) u_chk (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .mute        (mute),
    .left_pcm    (left_pcm),
    .right_pcm   (right_pcm),
    .frame_valid (frame_valid)
);

// File: tb/tb_pcm_serial_rx.sv
`timescale 1ns/1ps
module tb_pcm_serial_rx;

    localparam int W    = 16;
    localparam int MAXL = 1024;

    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wclk = 1'b0;
    logic         sdata = 1'b0;
    logic         fmt_i2s = 1'b0;
    logic         mute = 1'b0;
    logic [W-1:0] left_pcm;
    logic [W-1:0] right_pcm;
    logic         frame_valid;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    logic [2*W-1:0] exp_q[$];
    logic           sd_arr[MAXL];
    logic           lr_arr[MAXL];
    int             len = 0;

    pcm_serial_rx #(.SAMPLE_W(W)) dut (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .wclk        (wclk),
        .sdata       (sdata),
        .fmt_i2s     (fmt_i2s),
        .mute        (mute),
        .left_pcm    (left_pcm),
        .right_pcm   (right_pcm),
        .frame_valid (frame_valid)
    );

    always #2.5 bclk = ~bclk;

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: compare every strobe against the queue
    logic           prev_valid = 1'b0;
    logic [2*W-1:0] prev_out = '0;
    logic           prev_rst = 1'b0;
    always @(negedge bclk) begin
        if (rst_n && prev_rst) begin
            if (frame_valid) begin
                check(!prev_valid, "R5", {31'd0, prev_valid}, '0);
                if (exp_q.size() == 0)
                    check(1'b0, "R5", {left_pcm, right_pcm}, '0);
                else begin
                    logic [2*W-1:0] e;
                    e = exp_q.pop_front();
                    check({left_pcm, right_pcm} == e, tag, {left_pcm, right_pcm}, e);
                end
            end else if (!mute) begin
                check({left_pcm, right_pcm} == prev_out, "R6", {left_pcm, right_pcm}, prev_out);
            end
        end
        prev_valid = frame_valid;
        prev_out   = {left_pcm, right_pcm};
        prev_rst   = rst_n;
    end

    task automatic clear_stream();
        for (int i = 0; i < MAXL; i++) begin
            sd_arr[i] = 1'($urandom);
            lr_arr[i] = 1'b0;
        end
        len = 0;
    endtask

    task automatic add_lead(input int n, input logic lrv);
        for (int i = 0; i < n; i++) lr_arr[len + i] = lrv;
        len += n;
    endtask

    task automatic add_half(input logic lrv, input int h, input logic [W-1:0] w, input logic i2s);
        for (int i = 0; i < h; i++) lr_arr[len + i] = lrv;
        for (int b = 0; b < W; b++) begin
            if (i2s) sd_arr[len + 1 + b] = w[W-1-b];
            else     sd_arr[len + h - W + b] = w[W-1-b];
        end
        len += h;
    endtask

    // Driver: append one frame and push the expected pair
    task automatic add_frame(input int h, input logic [W-1:0] l, input logic [W-1:0] r);
        logic lv;
        lv = fmt_i2s ? 1'b0 : 1'b1;
        add_half(lv, h, l, fmt_i2s);
        add_half(~lv, h, r, fmt_i2s);
        exp_q.push_back(mute ? '0 : {l, r});
    endtask

    task automatic play();
        for (int i = 0; i < len; i++) begin
            @(negedge bclk); #1;
            wclk  = lr_arr[i];
            sdata = sd_arr[i];
        end
        repeat (4) @(negedge bclk);
        check(exp_q.size() == 0, "R8", 32'(exp_q.size()), '0);
        exp_q.delete();
    endtask

    task automatic start_run(input logic i2s, input logic m);
        @(negedge bclk); #1;
        fmt_i2s = i2s;
        mute    = m;
        wclk    = i2s ? 1'b1 : 1'b0;
        sdata   = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(negedge bclk);
        check({left_pcm, right_pcm} == '0 && !frame_valid, "R1", {left_pcm, right_pcm}, '0);
        #1 rst_n = 1'b1;
        @(negedge bclk);
        check({left_pcm, right_pcm} == '0 && !frame_valid, "R1", {left_pcm, right_pcm}, '0);
        clear_stream();
        add_lead(4, i2s ? 1'b1 : 1'b0);
    endtask

    task automatic finish_stream();
        add_lead(4, fmt_i2s ? 1'b0 : 1'b1);
        play();
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R2 and R4: right-aligned, packed frames
        tag = "R4";
        start_run(1'b0, 1'b0);
        add_frame(16, 16'h1234, 16'hABCD);
        add_frame(16, 16'hFFFF, 16'h0000);
        add_frame(16, 16'h8000, 16'h0001);
        add_frame(16, 16'h5A5A, 16'hC3C3);
        finish_stream();

        // R2: right-aligned with leading padding
        tag = "R2";
        start_run(1'b0, 1'b0);
        add_frame(24, 16'h0F0F, 16'hF00F);
        add_frame(24, 16'h7FFF, 16'h8001);
        add_frame(24, 16'hDEAD, 16'hBEEF);
        finish_stream();

        // R3 and R4: I2S packed frames (LSB in next half's first slot)
        tag = "R4";
        start_run(1'b1, 1'b0);
        add_frame(16, 16'hCAFE, 16'h0420);
        add_frame(16, 16'h0001, 16'h8000);
        add_frame(16, 16'hFFFF, 16'hFFFF);
        add_frame(16, 16'h1357, 16'h2468);
        finish_stream();

        // R3: I2S with trailing bits that must be ignored
        tag = "R3";
        start_run(1'b1, 1'b0);
        add_frame(32, 16'hA5A5, 16'h5A5A);
        add_frame(32, 16'h0000, 16'h7E7E);
        add_frame(32, 16'h9999, 16'h6666);
        finish_stream();

        // R7: mute clears live outputs on the next edge, stays clear after release
        @(negedge bclk); #1 mute = 1'b1;
        @(negedge bclk);
        check({left_pcm, right_pcm} == '0, "R7", {left_pcm, right_pcm}, '0);
        #1 mute = 1'b0;
        repeat (3) @(negedge bclk);
        check({left_pcm, right_pcm} == '0, "R7", {left_pcm, right_pcm}, '0);

        // R7: frames received under mute give zero pairs with strobes
        tag = "R7";
        start_run(1'b1, 1'b1);
        add_frame(20, 16'h4321, 16'h8765);
        add_frame(20, 16'hFFFF, 16'h1111);
        finish_stream();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule